// File: doc/BRIEF.md
# Transition Position Frame Decoder

This block turns a stream of 8-bit transition codewords, one per 125 µs frame, back into a binary data waveform. Each frame is split into 32 timeslots, and the block replays the coded transitions at slot resolution. A codeword tells the block where the first transition falls. It also gives a two-bit frame type and the data level at the end of the frame. The block XORs the level bit of the new frame with the level bit of the frame before. The result says whether an odd or an even number of transitions took place, and that parity picks between the meanings of each frame type. When a frame holds a second or third transition, the block puts it at a fixed offset from the first, not at a measured position.

A codeword is written with `cw_valid`. A one-cycle `frame_start` strobe then loads it for playback. The next 32 `slot_en` pulses step through slots 0 to 31. The data output changes only on a slot pulse. A violation pulse, which is a marker that carries no data change, shows on `viol` for the slot where it falls. If no codeword arrived before a frame strobe, the frame is replayed with no transitions at the previous level.

Top module: `tpf_decoder`

## Requirements
- R1: After reset, `data_out` is 1 (MARK), `viol` is 0, and the stored previous level is 1.
- R2: Codeword fields are: bit 7 = level L, bits 6..5 = type T, bits 4..0 = slot F. Let P = L XOR (previous frame's L). T=10 with P=1 gives one transition at slot F, so `data_out` toggles with the slot-F pulse.
- R3: T=10 with P=0 is a violation. `viol` is 1 after the slot-F pulse and 0 after every other slot pulse of the frame, and `data_out` does not change.
- R4: T=11, P=0, F=31 is an idle frame: `data_out` holds for all 32 slots.
- R5: T=11, P=0, F<17 gives two transitions, at slot F and at slot F+13.
- R6: T=11, P=1, F<4 gives three transitions, at slots F, F+13 and F+26.
- R7: T=01 gives a transition at slot F, plus a second one at slot F+27 when F+27 is 31 or less.
- R8: T=00 gives transitions at slot bits 1..0 and at slot (bits 4..2)+24.
- R9: With the slot-31 pulse, `data_out` becomes L of the current frame, even when the decoded transitions leave another level, including for T=11 codes not covered by R4 to R6, which place no transition.
- R10: A frame strobe with no codeword written since the last strobe replays a frame with no transitions, no violation and an unchanged previous level.
- R11: Outputs change only on a slot pulse or a reset, and each frame strobe clears `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Writes `cw_in` as the codeword for the next frame |
| cw_in | input | 8 | Transition codeword |
| frame_start | input | 1 | One-cycle strobe that begins a frame and loads the pending codeword |
| slot_en | input | 1 | Slot-rate enable; the Nth pulse after a strobe plays slot N-1 |
| data_out | output | 1 | Regenerated NRZ data, registered |
| viol | output | 1 | Violation indication for the slot just played, registered |

## Verification
The bench checks the output after every slot pulse against a model built from the rules, so a transition placed one slot early or late fails at the slot where it lands. The cases it targets are these. For the two-transition and three-transition types, a decoder that ignores parity would replay the wrong count. For the long-offset type with F=4 and F=10, getting the in-frame test wrong either drops the slot-31 transition or wraps it into the frame. For the split-field type, swapping the sub-fields would move both edges. An invalid type-11 code whose level bit disagrees must still land on the level bit at slot 31, which a design without the end-of-frame correction misses. A frame strobe with no codeword must hold the previous level and leave the parity reference as it was.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  // frame type field values (bits 6..5 of the codeword)
  typedef enum logic [1:0] {
    FT_SPLIT  = 2'b00,
    FT_LONG   = 2'b01,
    FT_SINGLE = 2'b10,
    FT_MULTI  = 2'b11
  } ftype_e;
endpackage

// File: rtl/tpf_cw_latch.sv
module tpf_cw_latch #(
  parameter int CW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw_in,
  input  logic            frame_start,
  output logic [CW_W-1:0] pend_cw,
  output logic            pend_vld,
  output logic            prev_lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cw  <= '0;
      pend_vld <= 1'b0;
      prev_lvl <= 1'b1;
    end else begin
      if (frame_start && pend_vld)
        prev_lvl <= pend_cw[CW_W-1];
      if (cw_valid) begin
        pend_cw  <= cw_in;
        pend_vld <= 1'b1;
      end else if (frame_start) begin
        pend_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpf_pos_decode.sv
module tpf_pos_decode
  import tpf_pkg::*;
#(
  parameter int CW_W       = 8,
  parameter int SLOTS      = 32,
  parameter int STEP_SHORT = 13,
  parameter int STEP_LONG  = 27,
  parameter int SPLIT_BASE = 24,
  parameter int PAIR_LIMIT = 17,
  parameter int TRIO_LIMIT = 4,
  parameter int SPLIT_LO_W = 2
) (
  input  logic            have,
  input  logic [CW_W-1:0] cw,
  input  logic            prev_lvl,
  output logic [SLOTS-1:0] tgl_mask,
  output logic [SLOTS-1:0] vio_mask,
  output logic             end_lvl
);
  localparam int POS_W = $clog2(SLOTS);
  localparam int PW    = POS_W + 2;
  localparam int HI_W  = POS_W - SPLIT_LO_W;

  ftype_e           ft;
  logic [POS_W-1:0] fs;
  logic             par;
  logic [PW-1:0]    p0, p1, p2, vp;
  logic             p0v, p1v, p2v, vv;

  assign ft      = ftype_e'(cw[CW_W-2:CW_W-3]);
  assign fs      = cw[POS_W-1:0];
  assign par     = cw[CW_W-1] ^ prev_lvl;
  assign end_lvl = have ? cw[CW_W-1] : prev_lvl;

  always_comb begin
    p0  = PW'(fs);
    p1  = PW'(fs) + PW'(STEP_SHORT);
    p2  = PW'(fs) + PW'(2 * STEP_SHORT);
    vp  = PW'(fs);
    p0v = 1'b0;
    p1v = 1'b0;
    p2v = 1'b0;
    vv  = 1'b0;
    if (have) begin
      unique case (ft)
        FT_MULTI: begin
          if (!par && (PW'(fs) < PW'(PAIR_LIMIT))) begin
            p0v = 1'b1;
            p1v = 1'b1;
          end else if (par && (PW'(fs) < PW'(TRIO_LIMIT))) begin
            p0v = 1'b1;
            p1v = 1'b1;
            p2v = 1'b1;
          end
        end
        FT_SINGLE: begin
          p0v = par;
          vv  = !par;
        end
        FT_LONG: begin
          p0v = 1'b1;
          p1  = PW'(fs) + PW'(STEP_LONG);
          p1v = (PW'(fs) + PW'(STEP_LONG)) < PW'(SLOTS);
        end
        FT_SPLIT: begin
          p0  = PW'(fs[SPLIT_LO_W-1:0]);
          p1  = PW'(fs[POS_W-1 -: HI_W]) + PW'(SPLIT_BASE);
          p0v = 1'b1;
          p1v = 1'b1;
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign tgl_mask[i] = (p0v && (p0 == PW'(i))) ^
                         (p1v && (p1 == PW'(i))) ^
                         (p2v && (p2 == PW'(i)));
    assign vio_mask[i] = vv && (vp == PW'(i));
  end
endmodule

// File: rtl/tpf_slot_player.sv
module tpf_slot_player #(
  parameter int SLOTS = 32,
  localparam int POS_W = $clog2(SLOTS),
  localparam int CNT_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             slot_en,
  input  logic [SLOTS-1:0] tgl_mask,
  input  logic [SLOTS-1:0] vio_mask,
  input  logic             end_lvl,
  output logic             data_out,
  output logic             viol,
  output logic [CNT_W-1:0] cnt_q,
  output logic             lvl_q
);
  logic [SLOTS-1:0] tgl_q, vio_q;
  logic             active, last;

  assign active = cnt_q < CNT_W'(SLOTS);
  assign last   = cnt_q == CNT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= CNT_W'(SLOTS);
      tgl_q    <= '0;
      vio_q    <= '0;
      lvl_q    <= 1'b1;
      data_out <= 1'b1;
      viol     <= 1'b0;
    end else if (frame_start) begin
      cnt_q <= '0;
      tgl_q <= tgl_mask;
      vio_q <= vio_mask;
      lvl_q <= end_lvl;
      viol  <= 1'b0;
    end else if (slot_en) begin
      if (active) begin
        data_out <= last ? lvl_q : (data_out ^ tgl_q[cnt_q[POS_W-1:0]]);
        viol     <= vio_q[cnt_q[POS_W-1:0]];
        cnt_q    <= cnt_q + 1'b1;
      end else begin
        viol <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpf_decoder.sv
module tpf_decoder #(
  parameter int CW_W       = 8,
  parameter int SLOTS      = 32,
  parameter int STEP_SHORT = 13,
  parameter int STEP_LONG  = 27,
  parameter int SPLIT_BASE = 24,
  parameter int PAIR_LIMIT = 17,
  parameter int TRIO_LIMIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cw_valid,
  input  logic [CW_W-1:0] cw_in,
  input  logic            frame_start,
  input  logic            slot_en,
  output logic            data_out,
  output logic            viol
);
  localparam int CNT_W = $clog2(SLOTS) + 1;

  logic [CW_W-1:0]  pend_cw;
  logic             pend_vld, prev_lvl, end_lvl;
  logic [SLOTS-1:0] tgl_mask, vio_mask;
  logic [CNT_W-1:0] play_cnt;
  logic             play_lvl;

  tpf_cw_latch #(.CW_W(CW_W)) u_latch (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_in(cw_in),
    .frame_start(frame_start), .pend_cw(pend_cw), .pend_vld(pend_vld),
    .prev_lvl(prev_lvl)
  );

  tpf_pos_decode #(
    .CW_W(CW_W), .SLOTS(SLOTS), .STEP_SHORT(STEP_SHORT), .STEP_LONG(STEP_LONG),
    .SPLIT_BASE(SPLIT_BASE), .PAIR_LIMIT(PAIR_LIMIT), .TRIO_LIMIT(TRIO_LIMIT),
    .SPLIT_LO_W(2)
  ) u_dec (
    .have(pend_vld), .cw(pend_cw), .prev_lvl(prev_lvl),
    .tgl_mask(tgl_mask), .vio_mask(vio_mask), .end_lvl(end_lvl)
  );

  tpf_slot_player #(.SLOTS(SLOTS)) u_play (
    .clk(clk), .rst(rst), .frame_start(frame_start), .slot_en(slot_en),
    .tgl_mask(tgl_mask), .vio_mask(vio_mask), .end_lvl(end_lvl),
    .data_out(data_out), .viol(viol), .cnt_q(play_cnt), .lvl_q(play_lvl)
  );
endmodule

// File: rtl/tpf_decoder_chk.sv
module tpf_decoder_chk #(
  parameter int SLOTS = 32,
  localparam int CNT_W = $clog2(SLOTS) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             slot_en,
  input logic             data_out,
  input logic             viol,
  input logic [CNT_W-1:0] play_cnt,
  input logic             play_lvl
);
  // R11: data moves only on a slot pulse
  p_data_on_slot_r11: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(data_out));

  // R11: a violation flag can only appear through a slot pulse
  p_viol_rise_slot_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $past(slot_en));

  // R3: a violation slot never changes the data
  p_viol_no_edge_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(viol) |-> $stable(data_out));

  // R9: the last slot lands on the frame's level bit
  p_end_level_r9: assert property (@(posedge clk) disable iff (rst)
    (slot_en && !frame_start && play_cnt == CNT_W'(SLOTS - 1)) |=> (data_out == play_lvl));

  // R11: a frame strobe clears the violation flag
  p_frame_clears_r11: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !viol);
endmodule

bind tpf_decoder tpf_decoder_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .slot_en(slot_en),
  .data_out(data_out), .viol(viol), .play_cnt(play_cnt), .play_lvl(play_lvl)
);

// File: tb/tb_tpf_decoder.sv
`timescale 1ns/1ps
module tb_tpf_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cw_valid = 1'b0;
  logic [7:0] cw_in = '0;
  logic       frame_start = 1'b0;
  logic       slot_en = 1'b0;
  logic       data_out, viol;

  int checks = 0;
  int fails  = 0;
  logic  m_prev = 1'b1;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  tpf_decoder dut (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_in(cw_in),
    .frame_start(frame_start), .slot_en(slot_en),
    .data_out(data_out), .viol(viol)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {data,viol} actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: compare after every slot pulse
  initial begin
    forever begin
      @(posedge clk);
      if (slot_en === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R11 unexpected slot", {data_out, viol}, 2'bxx);
        end else begin
          check(tag_q.pop_front(), {data_out, viol}, exp_q.pop_front());
        end
      end
    end
  end

  // model from the requirements; pushes 32 expected samples
  task automatic expect_frame(input bit have, input logic [7:0] cw, input string tag);
    int pos[$];
    int vpos = -1;
    int f = int'(cw[4:0]);
    logic p = cw[7] ^ m_prev;
    logic lvl = m_prev;
    if (have) begin
      case (cw[6:5])
        2'b11: begin
          if (!p && f < 17 && f != 31) begin pos.push_back(f); pos.push_back(f + 13); end
          else if (p && f < 4) begin pos.push_back(f); pos.push_back(f + 13); pos.push_back(f + 26); end
        end
        2'b10: if (p) pos.push_back(f); else vpos = f;
        2'b01: begin pos.push_back(f); if (f + 27 <= 31) pos.push_back(f + 27); end
        default: begin pos.push_back(int'(cw[1:0])); pos.push_back(int'(cw[4:2]) + 24); end
      endcase
    end
    for (int s = 0; s < 32; s++) begin
      foreach (pos[k]) if (pos[k] == s) lvl = ~lvl;
      if (s == 31 && have) lvl = cw[7];
      exp_q.push_back({lvl, (s == vpos)});
      tag_q.push_back($sformatf("%s slot %0d", tag, s));
    end
    if (have) m_prev = cw[7];
  endtask

  task automatic run_frame(input bit have, input logic [7:0] cw, input string tag);
    expect_frame(have, cw, tag);
    if (have) begin
      @(negedge clk); cw_valid = 1'b1; cw_in = cw;
      @(negedge clk); cw_valid = 1'b0;
    end
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); slot_en = 1'b1;
      @(negedge clk); slot_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", {data_out, viol}, 2'b10);
    run_frame(1'b0, 8'h00, "R10 no codeword");
    run_frame(1'b1, 8'hFF, "R4 idle frame");
    run_frame(1'b1, 8'h45, "R2 single F=5");
    run_frame(1'b1, 8'h49, "R3 violation F=9");
    run_frame(1'b1, 8'h63, "R5 pair F=3");
    run_frame(1'b1, 8'hE2, "R6 trio F=2");
    run_frame(1'b0, 8'h00, "R10 hold high");
    run_frame(1'b1, 8'hA4, "R7 long F=4");
    run_frame(1'b1, 8'h2A, "R7 long F=10");
    run_frame(1'b1, 8'h16, "R8 split");
    run_frame(1'b1, 8'hFF, "R9 mismatch force");
    run_frame(1'b1, 8'hF4, "R9 invalid pair");
    run_frame(1'b1, 8'h5F, "R2 single F=31");
    repeat (4) @(negedge clk);
    check("R11 queue drained", {1'b0, exp_q.size() != 0}, 2'b00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule